// File: doc/BRIEF.md
# SPI Register, Strobe and FIFO Port Slave

This block is the serial control port of a radio-style control chip. An external host drives an SPI bus (mode 0, most significant bit first). Each transfer opens with a header byte that carries a direction bit, a burst bit and a 6-bit address. While the header shifts in, the block shifts out a live status byte on MISO. That byte holds the chip-ready flag, the 3-bit main state code, and a saturating FIFO byte count whose meaning follows the header's direction bit.

The address selects one of four targets: a bank of read/write configuration registers, a window shared by read-only status registers and command strobes, a FIFO port, and unmapped addresses. In the shared window the burst bit chooses the target: with burst set, the address names a status register, and with burst clear, it names a command strobe. The FIFO port writes a 64-byte transmit buffer and reads a 64-byte receive buffer. The radio side of both buffers is brought out to plain ports. Burst accesses step the address after every byte until chip select rises. A byte that chip select cuts short is dropped.

SCLK, CS and MOSI are sampled in a faster system clock through two-flop synchronisers. The main state code and the status register values are inputs.

Top module: `spi_regport`

## Requirements
- R1: The header byte is decoded as bit 7 = read (1) / write (0), bit 6 = burst, bits 5:0 = address. MOSI is sampled on SCLK rising edges, MSB first, and MISO changes after SCLK falling edges.
- R2: While a header byte shifts in, MISO returns the status byte {chip_rdy_n, state_i[2:0], count[3:0]}. When the header's bit 7 is 1, count is the number of receive FIFO bytes. When bit 7 is 0, count is the number of free transmit FIFO bytes. The count saturates at 15.
- R3: Addresses 0x00 to 0x2E are configuration registers. A write data byte produces one cfg_we pulse with cfg_waddr and cfg_wdata, and the value is stored. A read returns the stored value in the data byte.
- R4: With the burst bit set, each further data byte goes to the next address until CS rises. Bytes whose address has moved past 0x2E are dropped and read as 0x00.
- R5: At addresses 0x30 to 0x3D with burst=1, a read returns stat_i[8*(addr-0x30) +: 8] in one data byte, after which a new header is expected. A write to this window is ignored.
- R6: At addresses 0x30 to 0x3D with burst=0, the header alone is a command strobe and gives a one-cycle pulse on strobe_o[addr-0x30]. The strobes at 0x32 and 0x39 pulse only when CS next rises. All others pulse right after the header.
- R7: Address 0x3F is the FIFO port. Writes push into the transmit FIFO and reads pop the receive FIFO, with 0x00 returned when it is empty. With burst=0 one data byte is moved. With burst=1 bytes are moved until CS rises. A byte is popped only once its transfer completes.
- R8: While write data bytes shift in, MISO returns the status byte with the transmit free count taken before that byte is stored. Read data bytes return data only.
- R9: If CS rises part-way through a header or data byte, that byte causes no register write, strobe, push or pop.
- R10: Strobe 0x3A empties the receive FIFO and strobe 0x3B empties the transmit FIFO, but only while state_i is 0 (idle), 6 (receive overflow) or 7 (transmit underflow).
- R11: Addresses 0x2F and 0x3E are unmapped. Writes to them are ignored and reads return 0x00.
- R12: After reset the configuration registers hold 0x00, both FIFOs are empty, and cfg_we, strobe_o, tx_push_o and rx_pop_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock (asynchronous) |
| cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| chip_rdy_n | input | 1 | Chip-ready flag reported in status bit 7 (0 = ready) |
| state_i | input | 3 | Main state code reported in status bits 6:4 |
| stat_i | input | 112 | Status register values, byte k at bits 8k+7:8k |
| cfg_we | output | 1 | One-cycle configuration write pulse |
| cfg_waddr | output | 6 | Configuration write address |
| cfg_wdata | output | 8 | Configuration write data |
| strobe_o | output | 14 | Command strobe pulses, bit k for address 0x30+k |
| tx_push_o | output | 1 | Pulse when a byte enters the transmit FIFO |
| tx_pop | input | 1 | Radio side removes the head of the transmit FIFO |
| tx_q | output | 8 | Head of the transmit FIFO |
| rx_push | input | 1 | Radio side writes rx_d into the receive FIFO |
| rx_d | input | 8 | Receive FIFO write data |
| rx_pop_o | output | 1 | Pulse when a byte leaves the receive FIFO |

## Verification
On every cycle, the in-line assertions check several properties. At most one strobe line is high, and the two power-down strobes appear only right after chip select rises. Configuration writes never leave the configuration range or occur while chip select is high. The flush requests respect the state gate, and neither buffer is pushed when full or popped when empty. The exact bits on MISO can be shown only by the bench's transfers: the direction-dependent saturating count, the free count taken before storing a byte, burst addresses crossing out of range, and dropped partial bytes.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam logic [5:0] CFG_LAST  = 6'h2E;
  localparam logic [5:0] WIN_LO    = 6'h30;
  localparam logic [5:0] WIN_HI    = 6'h3D;
  localparam logic [5:0] FIFO_ADDR = 6'h3F;
  localparam logic [5:0] STB_XOFF  = 6'h32;
  localparam logic [5:0] STB_PWD   = 6'h39;
  localparam logic [5:0] STB_FRX   = 6'h3A;
  localparam logic [5:0] STB_FTX   = 6'h3B;
  localparam int         NUM_WIN   = int'(WIN_HI - WIN_LO) + 1;
  localparam int         NUM_CFG   = int'(CFG_LAST) + 1;
  localparam logic [2:0] ST_IDLE   = 3'd0;
  localparam logic [2:0] ST_RXOVF  = 3'd6;
  localparam logic [2:0] ST_TXUNF  = 3'd7;

  typedef enum logic [2:0] {
    PH_HDR, PH_CFG, PH_STAT, PH_FIFO, PH_DROP
  } phase_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] m1, m2, m3;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1 <= RST_VAL;
      m2 <= RST_VAL;
      m3 <= RST_VAL;
    end else begin
      m1 <= d;
      m2 <= m1;
      m3 <= m2;
    end
  end

  assign q    = m2;
  assign rise = m2 & ~m3;
  assign fall = ~m2 & m3;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst)
    push |-> count != CW'(DEPTH));  // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);  // R7
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  input  logic               chip_rdy_n,
  input  logic [2:0]         state_i,
  input  logic [NUM_WIN*8-1:0] stat_i,
  output logic               cfg_we,
  output logic [5:0]         cfg_waddr,
  output logic [7:0]         cfg_wdata,
  output logic [NUM_WIN-1:0] strobe_o,
  output logic               tx_push_o,
  input  logic               tx_pop,
  output logic [7:0]         tx_q,
  input  logic               rx_push,
  input  logic [7:0]         rx_d,
  output logic               rx_pop_o
);
  localparam logic [3:0] PWD_IDX  = 4'(STB_PWD - WIN_LO);
  localparam logic [3:0] XOFF_IDX = 4'(STB_XOFF - WIN_LO);

  logic [2:0] sq, srise, sfall;
  logic cs_s, cs_rise, cs_fall, sclk_rise, sclk_fall, mosi_s;

  spi_edge_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, mosi}),
    .q(sq), .rise(srise), .fall(sfall)
  );
  assign cs_s      = sq[2];
  assign cs_rise   = srise[2];
  assign cs_fall   = sfall[2];
  assign sclk_rise = srise[1];
  assign sclk_fall = sfall[1];
  assign mosi_s    = sq[0];

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_q, tx_wd;
  logic          flush_rx, flush_tx;

  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst(rst), .flush(flush_tx), .push(tx_push_o), .wdata(tx_wd),
    .pop(tx_pop), .rdata(tx_q), .count(tx_cnt)
  );
  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .flush(flush_rx), .push(rx_push), .wdata(rx_d),
    .pop(rx_pop_o), .rdata(rx_q), .count(rx_cnt)
  );

  function automatic logic [3:0] sat4(input logic [CW-1:0] v);
    return (v > CW'(15)) ? 4'hF : v[3:0];
  endfunction

  phase_t     phase;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic       rw, burst, live, dir;
  logic [5:0] addr;
  logic [7:0] out_byte;
  logic [7:0] cfg [NUM_CFG];
  logic       pend_pwd, pend_xoff;

  logic [7:0]    rx_byte, st_now, src_byte;
  logic [CW-1:0] tx_free;
  logic [5:0]    h_addr, a_next;
  logic [3:0]    sidx;
  logic          in_win, rd_fifo, flush_ok, rx_has;

  assign rx_byte  = {shreg, mosi_s};
  assign h_addr   = rx_byte[5:0];
  assign sidx     = 4'(h_addr - WIN_LO);
  assign in_win   = (h_addr >= WIN_LO) && (h_addr <= WIN_HI);
  assign a_next   = addr + 6'd1;
  assign tx_free  = CW'(FIFO_DEPTH) - tx_cnt;
  assign rx_has   = (rx_cnt != '0);
  assign st_now   = {chip_rdy_n, state_i, sat4(dir ? rx_cnt : tx_free)};
  assign rd_fifo  = (phase == PH_FIFO) && rw;
  assign src_byte = live ? st_now : (rd_fifo ? (rx_has ? rx_q : 8'h00) : out_byte);
  assign flush_ok = (state_i == ST_IDLE) || (state_i == ST_RXOVF) || (state_i == ST_TXUNF);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_HDR;  bitcnt <= '0;  shreg <= '0;
      rw <= 1'b0;  burst <= 1'b0;  live <= 1'b1;  dir <= 1'b0;
      addr <= '0;  out_byte <= '0;  miso <= 1'b0;
      pend_pwd <= 1'b0;  pend_xoff <= 1'b0;
      cfg_we <= 1'b0;  cfg_waddr <= '0;  cfg_wdata <= '0;
      strobe_o <= '0;  tx_push_o <= 1'b0;  tx_wd <= '0;  rx_pop_o <= 1'b0;
      flush_rx <= 1'b0;  flush_tx <= 1'b0;
      for (int i = 0; i < NUM_CFG; i++) cfg[i] <= '0;
    end else begin
      cfg_we <= 1'b0;  strobe_o <= '0;  tx_push_o <= 1'b0;  rx_pop_o <= 1'b0;
      flush_rx <= 1'b0;  flush_tx <= 1'b0;
      if (cs_rise) begin
        phase <= PH_HDR;  bitcnt <= '0;  live <= 1'b1;  dir <= 1'b0;
        strobe_o[PWD_IDX]  <= pend_pwd;
        strobe_o[XOFF_IDX] <= pend_xoff;
        pend_pwd <= 1'b0;  pend_xoff <= 1'b0;
      end else if (cs_fall) begin
        phase <= PH_HDR;  bitcnt <= '0;  live <= 1'b1;  dir <= 1'b0;
        miso <= chip_rdy_n;
      end else if (!cs_s) begin
        if (sclk_rise) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (phase == PH_HDR && bitcnt == 3'd0) dir <= mosi_s;
          if (bitcnt == 3'd7) begin
            if (phase == PH_HDR) begin
              rw <= rx_byte[7];  burst <= rx_byte[6];  addr <= h_addr;
              live <= ~rx_byte[7];
              if (h_addr <= CFG_LAST) begin
                phase <= PH_CFG;  out_byte <= cfg[h_addr];
              end else if (in_win && rx_byte[6]) begin
                phase <= PH_STAT;  out_byte <= stat_i[{sidx, 3'b000} +: 8];
              end else if (in_win) begin
                live <= 1'b1;
                if (h_addr == STB_PWD)       pend_pwd  <= 1'b1;
                else if (h_addr == STB_XOFF) pend_xoff <= 1'b1;
                else                         strobe_o[sidx] <= 1'b1;
                if (h_addr == STB_FRX && flush_ok) flush_rx <= 1'b1;
                if (h_addr == STB_FTX && flush_ok) flush_tx <= 1'b1;
              end else if (h_addr == FIFO_ADDR) begin
                phase <= PH_FIFO;
              end else begin
                phase <= PH_DROP;  out_byte <= 8'h00;
              end
            end else begin
              case (phase)
                PH_CFG: begin
                  if (!rw && addr <= CFG_LAST) begin
                    cfg[addr] <= rx_byte;
                    cfg_we <= 1'b1;  cfg_waddr <= addr;  cfg_wdata <= rx_byte;
                  end
                  if (burst) begin
                    addr     <= a_next;
                    out_byte <= (a_next <= CFG_LAST) ? cfg[a_next] : 8'h00;
                  end else begin
                    phase <= PH_HDR;  live <= 1'b1;
                  end
                end
                PH_FIFO: begin
                  if (!rw) begin
                    if (tx_cnt != CW'(FIFO_DEPTH)) begin
                      tx_push_o <= 1'b1;  tx_wd <= rx_byte;
                    end
                  end else begin
                    rx_pop_o <= rx_has;
                  end
                  if (!burst) begin
                    phase <= PH_HDR;  live <= 1'b1;
                  end
                end
                PH_DROP: begin
                  if (!burst) begin
                    phase <= PH_HDR;  live <= 1'b1;
                  end
                end
                default: begin
                  phase <= PH_HDR;  live <= 1'b1;
                end
              endcase
            end
          end
        end
        if (sclk_fall) miso <= src_byte[~bitcnt];
      end
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe_o));  // R6
  AST_PWD_DEFERRED: assert property (@(posedge clk) disable iff (rst)
    strobe_o[PWD_IDX] |-> $past(cs_rise));  // R6
  AST_XOFF_DEFERRED: assert property (@(posedge clk) disable iff (rst)
    strobe_o[XOFF_IDX] |-> $past(cs_rise));  // R6
  AST_CFG_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> cfg_waddr <= CFG_LAST);  // R3
  AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> !cfg_we && !tx_push_o);  // R9
  AST_FLUSH_GATED: assert property (@(posedge clk) disable iff (rst)
    (flush_rx || flush_tx) |-> ($past(state_i) == ST_IDLE || $past(state_i) == ST_RXOVF
                                || $past(state_i) == ST_TXUNF));  // R10
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic chip_rdy_n = 1'b0;
  logic [2:0] state_i = 3'd0;
  logic [111:0] stat_i;
  logic cfg_we;  logic [5:0] cfg_waddr;  logic [7:0] cfg_wdata;
  logic [13:0] strobe_o;
  logic tx_push_o, tx_pop = 1'b0, rx_push = 1'b0, rx_pop_o;
  logic [7:0] tx_q, rx_d = 8'h00;

  int nchk = 0, nerr = 0, we_cnt = 0;
  int stb_cnt [14];
  logic [7:0] r;

  always #10 clk = ~clk;

  for (genvar k = 0; k < 14; k++) begin : g_stat
    assign stat_i[8*k +: 8] = 8'h40 + 8'(k);
  end

  spi_regport u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .chip_rdy_n(chip_rdy_n), .state_i(state_i), .stat_i(stat_i),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .strobe_o(strobe_o), .tx_push_o(tx_push_o), .tx_pop(tx_pop), .tx_q(tx_q),
    .rx_push(rx_push), .rx_d(rx_d), .rx_pop_o(rx_pop_o)
  );

  initial for (int k = 0; k < 14; k++) stb_cnt[k] = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (cfg_we) we_cnt <= we_cnt + 1;
      for (int k = 0; k < 14; k++) if (strobe_o[k]) stb_cnt[k] <= stb_cnt[k] + 1;
    end
  end

  // {header, data sent, expected header reply, expected data reply}
  localparam logic [31:0] VECS [12] = '{
    32'h00A50F0F,  // R3 write cfg 0x00
    32'h2E3C0F0F,  // R3 write cfg 0x2E
    32'h800000A5,  // R3 read cfg 0x00
    32'hAE00003C,  // R3 read cfg 0x2E
    32'h2F770F0F,  // R11 write unmapped 0x2F
    32'hAF000000,  // R11 read unmapped 0x2F
    32'h3E550F0F,  // R11 write unmapped 0x3E
    32'hBE000000,  // R11 read unmapped 0x3E
    32'hF0000040,  // R5 status 0x30
    32'hFD00004D,  // R5 status 0x3D
    32'h70990F0F,  // R5 write to status ignored
    32'hF3000043   // R5 status 0x33
  };

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cs_down;
    cs_n = 1'b0;
  endtask

  task automatic cs_up;
    wclk(HALF);
    cs_n = 1'b1;
    wclk(8);
  endtask

  task automatic sbits(input logic [7:0] t, input int n, output logic [7:0] rr);
    rr = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = t[i];
      wclk(HALF);
      rr[i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sbyte(input logic [7:0] t, output logic [7:0] rr);
    sbits(t, 8, rr);
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(5);

    // R12: reset state
    chk("R12 cfg_we", 32'(cfg_we), 0);
    chk("R12 strobe_o", 32'(strobe_o), 0);
    chk("R12 tx_push_o/rx_pop_o", 32'({tx_push_o, rx_pop_o}), 0);
    cs_down;
    sbyte(8'h85, r);  chk("R12 header reply rx empty", 32'(r), 32'h00);
    sbyte(8'h00, r);  chk("R12 cfg 0x05 reset value", 32'(r), 32'h00);
    cs_up;

    // R1: header decode across the vector table
    for (int v = 0; v < 12; v++) begin
      logic [7:0] r0, r1;
      cs_down;
      sbyte(VECS[v][31:24], r0);
      sbyte(VECS[v][23:16], r1);
      cs_up;
      chk($sformatf("R1 vector %0d header reply", v), 32'(r0), 32'(VECS[v][15:8]));
      chk($sformatf("R1 vector %0d data reply", v), 32'(r1), 32'(VECS[v][7:0]));
    end
    chk("R11 only two cfg writes", we_cnt, 2);

    // R4: burst write and read, then burst crossing the top of the range
    cs_down;
    sbyte(8'h50, r);  sbyte(8'h11, r);  sbyte(8'h22, r);  sbyte(8'h33, r);
    cs_up;
    chk("R4 burst write pulses", we_cnt, 5);
    cs_down;
    sbyte(8'hD0, r);
    sbyte(8'h00, r);  chk("R4 burst read 0x10", 32'(r), 32'h11);
    sbyte(8'h00, r);  chk("R4 burst read 0x11", 32'(r), 32'h22);
    sbyte(8'h00, r);  chk("R4 burst read 0x12", 32'(r), 32'h33);
    cs_up;
    cs_down;
    sbyte(8'h6D, r);  sbyte(8'h61, r);  sbyte(8'h62, r);  sbyte(8'h63, r);
    cs_up;
    chk("R4 burst stops at 0x2E", we_cnt, 7);
    cs_down;  sbyte(8'hAE, r);  sbyte(8'h00, r);  cs_up;
    chk("R4 cfg 0x2E after burst", 32'(r), 32'h62);

    // R2: state code and chip-ready in header reply
    state_i = 3'b101;  chip_rdy_n = 1'b1;
    cs_down;  sbyte(8'hBD, r);  cs_up;
    chk("R2 status byte", 32'(r), 32'hD0);
    chk("R6 strobe 0x3D", stb_cnt[13], 1);
    state_i = 3'd0;  chip_rdy_n = 1'b0;

    // R6: immediate and deferred strobes
    cs_down;
    sbyte(8'h36, r);
    wclk(4);
    chk("R6 strobe 0x36 immediate", stb_cnt[6], 1);
    sbyte(8'h39, r);
    wclk(20);
    chk("R6 strobe 0x39 held while CS low", stb_cnt[9], 0);
    cs_up;
    chk("R6 strobe 0x39 on CS rise", stb_cnt[9], 1);
    cs_down;  sbyte(8'h32, r);  sbyte(8'h3D, r);  wclk(4);
    chk("R6 strobe 0x32 held", stb_cnt[2], 0);
    cs_up;
    chk("R6 strobe 0x32 on CS rise", stb_cnt[2], 1);

    // R7 / R8: burst transmit FIFO write, saturating free count
    cs_down;
    sbyte(8'h7F, r);  chk("R8 TX header reply", 32'(r), 32'h0F);
    for (int i = 0; i < 52; i++) begin
      int fr;
      fr = 64 - i;
      sbyte(8'(i + 1), r);
      chk($sformatf("R8 TX byte %0d free count", i), 32'(r), (fr > 15) ? 32'h0F : 32'(fr));
    end
    cs_up;
    chk("R7 TX head", 32'(tx_q), 32'h01);
    tx_pop = 1'b1;  wclk(1);  tx_pop = 1'b0;  wclk(4);
    chk("R7 TX next head", 32'(tx_q), 32'h02);

    // R10: TX flush refused in state 1, accepted in state 7
    state_i = 3'd1;
    cs_down;  sbyte(8'h3B, r);  sbyte(8'h3D, r);  cs_up;
    chk("R10 TX flush refused", 32'(r), 32'h1D);
    state_i = 3'd7;
    cs_down;  sbyte(8'h3B, r);  sbyte(8'h3D, r);  cs_up;
    chk("R10 TX flush accepted", 32'(r), 32'h7F);
    state_i = 3'd0;

    // R7: receive FIFO single then burst read
    for (int i = 0; i < 3; i++) begin
      rx_d = 8'hA1 + 8'(i);  rx_push = 1'b1;  wclk(1);  rx_push = 1'b0;
    end
    wclk(3);
    cs_down;
    sbyte(8'hBF, r);  chk("R2 RX count header", 32'(r), 32'h03);
    sbyte(8'h00, r);  chk("R7 RX single read", 32'(r), 32'hA1);
    sbyte(8'hFF, r);  chk("R7 RX count after pop", 32'(r), 32'h02);
    sbyte(8'h00, r);  chk("R7 RX burst byte 1", 32'(r), 32'hA2);
    sbyte(8'h00, r);  chk("R7 RX burst byte 2", 32'(r), 32'hA3);
    sbyte(8'h00, r);  chk("R7 RX empty reads zero", 32'(r), 32'h00);
    cs_up;
    cs_down;  sbyte(8'hBD, r);  cs_up;
    chk("R7 RX empty count", 32'(r), 32'h00);

    // R9: aborted data byte and aborted header
    cs_down;  sbyte(8'h00, r);  sbits(8'hFF, 4, r);  cs_up;
    cs_down;  sbits(8'h80, 3, r);  cs_up;
    chk("R9 no write from partial byte", we_cnt, 7);
    cs_down;  sbyte(8'h80, r);  sbyte(8'h00, r);  cs_up;
    chk("R9 cfg 0x00 intact", 32'(r), 32'hA5);

    // R10: RX flush refused in state 1, accepted in state 0
    for (int i = 0; i < 20; i++) begin
      rx_d = 8'(i);  rx_push = 1'b1;  wclk(1);  rx_push = 1'b0;
    end
    wclk(3);
    state_i = 3'd1;
    cs_down;  sbyte(8'hBA, r);  chk("R2 RX count saturates", 32'(r), 32'h1F);
    sbyte(8'hBD, r);  cs_up;
    chk("R10 RX flush refused", 32'(r), 32'h1F);
    state_i = 3'd0;
    cs_down;  sbyte(8'hBA, r);  sbyte(8'hBD, r);  cs_up;
    chk("R10 RX flush accepted", 32'(r), 32'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule